// File: doc/BRIEF.md
# DSP Status Flag Register

This block holds the 16-bit status word of a fixed-point DSP datapath. In each cycle it can take the condition indications of one ALU result: carry, zero, negative, overflow, and whether a value written to a 40-bit extended accumulator needed more than 32 bits. It also takes a strobe that says whether the current instruction is arithmetic or a transfer. Arithmetic instructions refresh the condition flags. Transfer instructions leave them alone.

Three overflow flags have different lifetimes. The per-result flag follows every arithmetic result. The sticky flag stays set until reset or a software write. The guard flag follows only results written to the extended accumulator. The upper bits store mode selections for the multiplier, the rounding and clipping datapaths, the DMA interrupt enable, and a set of interrupt enables. Those enables are qualified by a global enable. A software write port loads the whole word and wins over an arithmetic update in the same cycle.

The block drives the word itself, the four mode bits, gated requests for the external interrupt lines, and a one-cycle overflow interrupt pulse. This is control and status logic, so all pins are plain levels with no handshake.

Top module: `dsp_status_reg`

## Requirements
- R1: On reset (`rst_n` low) every status bit clears to 0, `ovf_irq` is 0 and `ext_irq_req` is 0.
- R2: When `op_valid` and `op_arith` are both 1, bit 0 (carry), bit 1 (zero) and bit 2 (negative) are loaded from `res_carry`, `res_zero` and `res_neg` at the next clock edge.
- R3: Bit 3 (per-result overflow) is loaded from `res_ovf` on every arithmetic update, both setting and clearing.
- R4: Bit 4 (sticky overflow) is set by an arithmetic update with `res_ovf` = 1. It stays set through later updates without overflow and clears only on reset or a software write.
- R5: Bit 5 (accumulator guard) changes only on an arithmetic update with `acc_wr` = 1. It takes the value of `acc_ext`: 1 means the result needed more than 32 bits, 0 means it fitted in 32 bits.
- R6: A transfer (`op_valid` = 1, `op_arith` = 0), or a cycle with `op_valid` = 0, leaves bits 0 to 5 unchanged.
- R7: When `sw_we` is 1, all 16 bits take `sw_wdata` at the next edge. This holds even if an arithmetic update is presented in the same cycle.
- R8: Bits 6 to 15 change only by software write. `int_mult_mode`, `round_mode`, `clip_mode` and `dma_irq_en` reflect bits 6, 7, 8 and 9.
- R9: `ext_irq_req[i]` is 1 exactly when `ext_irq_in[i]`, status bit 10+i, and global enable bit 15 are all 1.
- R10: `ovf_irq` is high for one cycle, in the cycle after the status edge where the condition ((bit 3 and bit 13) or (bit 5 and bit 14)) and bit 15 goes from 0 to 1. It does not repeat while the condition stays true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An instruction completes this cycle |
| op_arith | input | 1 | 1 = arithmetic, 0 = transfer |
| res_carry | input | 1 | Result produced a carry |
| res_zero | input | 1 | Result equals zero |
| res_neg | input | 1 | Result is below zero |
| res_ovf | input | 1 | Result overflowed |
| acc_wr | input | 1 | Result goes to the 40-bit accumulator |
| acc_ext | input | 1 | Accumulator result needed more than 32 bits |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 16 | Software write value |
| ext_irq_in | input | 3 | External interrupt lines |
| status | output | 16 | Current status word |
| int_mult_mode | output | 1 | Integer multiplication mode |
| round_mode | output | 1 | Rounding on narrowing transfers |
| clip_mode | output | 1 | Clip results on overflow |
| dma_irq_en | output | 1 | DMA interrupt enable |
| ext_irq_req | output | 3 | Gated external interrupt requests |
| ovf_irq | output | 1 | Overflow interrupt pulse |

## Verification
A software write and an arithmetic flag update can fall in the same cycle and compete for the same bits. The stimulus table places a write with a sticky overflow already set, together with an arithmetic op that carries overflow, carry and an extended-accumulator result. The judgement is that the word then equals the written value exactly: the sticky bit is clear, and neither the carry nor the guard flag picked up the arithmetic indication. The next arithmetic op must update from that written state.

// File: rtl/dsp_status_pkg.sv
package dsp_status_pkg;
  localparam int STAT_W      = 16;
  localparam int NUM_EXT_IRQ = 3;
  localparam int FLAG_W      = 6;
  localparam int CTRL_W      = STAT_W - FLAG_W;

  // bit positions in the status word
  localparam int B_C    = 0;
  localparam int B_Z    = 1;
  localparam int B_N    = 2;
  localparam int B_V1   = 3;
  localparam int B_V2   = 4;
  localparam int B_V3   = 5;
  localparam int B_IMUL = 6;
  localparam int B_RND  = 7;
  localparam int B_CLIP = 8;
  localparam int B_DMA  = 9;
  localparam int B_EXT0 = 10;
  localparam int B_OV1E = 13;
  localparam int B_OV3E = 14;
  localparam int B_GIE  = 15;

  // condition flags, msb first so the packed layout matches bits 5..0
  typedef struct packed {
    logic v3;
    logic v2;
    logic v1;
    logic neg;
    logic zero;
    logic carry;
  } cond_t;

  typedef struct packed {
    logic carry;
    logic zero;
    logic neg;
    logic ovf;
    logic acc_wr;
    logic acc_ext;
  } alu_ind_t;
endpackage

// File: rtl/dsp_cond_flags.sv
module dsp_cond_flags
  import dsp_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  alu_ind_t          ind,
  input  logic              sw_we,
  input  logic [FLAG_W-1:0] sw_flags,
  output cond_t             flags_q
);
  cond_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (sw_we) begin
      flags_d = cond_t'(sw_flags);
    end else if (upd_en) begin
      flags_d.carry = ind.carry;
      flags_d.zero  = ind.zero;
      flags_d.neg   = ind.neg;
      flags_d.v1    = ind.ovf;
      flags_d.v2    = flags_q.v2 | ind.ovf;
      if (ind.acc_wr) flags_d.v3 = ind.acc_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !sw_we) |=> $stable(flags_q)); // R6
  AST_V1_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !sw_we) |=> (flags_q.v1 == $past(ind.ovf))); // R3
  AST_V2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.v2 && !sw_we) |=> flags_q.v2); // R4
  AST_V3_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !(upd_en && ind.acc_wr)) |=> $stable(flags_q.v3)); // R5
endmodule

// File: rtl/dsp_ctrl_bits.sv
module dsp_ctrl_bits
  import dsp_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [CTRL_W-1:0] sw_ctrl,
  output logic [CTRL_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (sw_we) ctrl_q <= sw_ctrl;
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> $stable(ctrl_q)); // R8
endmodule

// File: rtl/dsp_irq_gen.sv
module dsp_irq_gen
  import dsp_status_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   v1,
  input  logic                   v3,
  input  logic                   ov1_en,
  input  logic                   ov3_en,
  input  logic                   gie,
  input  logic [NUM_EXT_IRQ-1:0] ext_in,
  input  logic [NUM_EXT_IRQ-1:0] ext_en,
  output logic                   ovf_irq,
  output logic [NUM_EXT_IRQ-1:0] ext_req
);
  logic cond_now;
  logic cond_prev;

  assign cond_now = gie & ((v1 & ov1_en) | (v3 & ov3_en));

  always_ff @(posedge clk) begin
    if (!rst_n) cond_prev <= 1'b0;
    else        cond_prev <= cond_now;
  end

  assign ovf_irq = cond_now & ~cond_prev;

  for (genvar g = 0; g < NUM_EXT_IRQ; g++) begin : g_ext
    assign ext_req[g] = ext_in[g] & ext_en[g] & gie;
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |=> !ovf_irq); // R10
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (!ovf_irq && ext_req == '0)); // R9
endmodule

// File: rtl/dsp_status_reg.sv
module dsp_status_reg
  import dsp_status_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic                   op_arith,
  input  logic                   res_carry,
  input  logic                   res_zero,
  input  logic                   res_neg,
  input  logic                   res_ovf,
  input  logic                   acc_wr,
  input  logic                   acc_ext,
  input  logic                   sw_we,
  input  logic [STAT_W-1:0]      sw_wdata,
  input  logic [NUM_EXT_IRQ-1:0] ext_irq_in,
  output logic [STAT_W-1:0]      status,
  output logic                   int_mult_mode,
  output logic                   round_mode,
  output logic                   clip_mode,
  output logic                   dma_irq_en,
  output logic [NUM_EXT_IRQ-1:0] ext_irq_req,
  output logic                   ovf_irq
);
  alu_ind_t          ind;
  cond_t             flags_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              upd_en;

  assign upd_en = op_valid & op_arith;
  assign ind    = '{carry: res_carry, zero: res_zero, neg: res_neg,
                    ovf: res_ovf, acc_wr: acc_wr, acc_ext: acc_ext};

  dsp_cond_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (upd_en),
    .ind      (ind),
    .sw_we    (sw_we),
    .sw_flags (sw_wdata[FLAG_W-1:0]),
    .flags_q  (flags_q)
  );

  dsp_ctrl_bits u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_we   (sw_we),
    .sw_ctrl (sw_wdata[STAT_W-1:FLAG_W]),
    .ctrl_q  (ctrl_q)
  );

  assign status = {ctrl_q, flags_q};

  assign int_mult_mode = status[B_IMUL];
  assign round_mode    = status[B_RND];
  assign clip_mode     = status[B_CLIP];
  assign dma_irq_en    = status[B_DMA];

  dsp_irq_gen u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .v1      (status[B_V1]),
    .v3      (status[B_V3]),
    .ov1_en  (status[B_OV1E]),
    .ov3_en  (status[B_OV3E]),
    .gie     (status[B_GIE]),
    .ext_in  (ext_irq_in),
    .ext_en  (status[B_EXT0 +: NUM_EXT_IRQ]),
    .ovf_irq (ovf_irq),
    .ext_req (ext_irq_req)
  );

  AST_SW_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> (status == $past(sw_wdata))); // R7
  AST_ARITH_CZN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !sw_we) |=> (status[B_N:B_C] == $past({res_neg, res_zero, res_carry}))); // R2
endmodule

// File: tb/dsp_status_reg_test.sv
module dsp_status_reg_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_arith;
  logic        res_carry, res_zero, res_neg, res_ovf, acc_wr, acc_ext;
  logic        sw_we;
  logic [15:0] sw_wdata;
  logic [2:0]  ext_irq_in;
  logic [15:0] status;
  logic        int_mult_mode, round_mode, clip_mode, dma_irq_en;
  logic [2:0]  ext_irq_req;
  logic        ovf_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  dsp_status_reg uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_arith(op_arith),
    .res_carry(res_carry), .res_zero(res_zero), .res_neg(res_neg),
    .res_ovf(res_ovf), .acc_wr(acc_wr), .acc_ext(acc_ext),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .ext_irq_in(ext_irq_in),
    .status(status), .int_mult_mode(int_mult_mode), .round_mode(round_mode),
    .clip_mode(clip_mode), .dma_irq_en(dma_irq_en),
    .ext_irq_req(ext_irq_req), .ovf_irq(ovf_irq)
  );

  // {sw_we, sw_wdata, op_valid, op_arith, {c,z,n,o,acc_wr,acc_ext}, exp_status, exp_irq}
  localparam int NV = 15;
  localparam logic [41:0] VEC [NV] = '{
    {1'b1, 16'hA000, 1'b0, 1'b0, 6'b000000, 16'hA000, 1'b0}, // R7 write GIE+OV1 enable
    {1'b0, 16'h0000, 1'b1, 1'b1, 6'b101000, 16'hA005, 1'b0}, // R2 carry, negative
    {1'b0, 16'h0000, 1'b1, 1'b1, 6'b010100, 16'hA01A, 1'b1}, // R3 R4 R10 overflow rises
    {1'b0, 16'h0000, 1'b1, 1'b1, 6'b010100, 16'hA01A, 1'b0}, // R10 held, no repeat
    {1'b0, 16'h0000, 1'b1, 1'b0, 6'b101000, 16'hA01A, 1'b0}, // R6 transfer ignored
    {1'b0, 16'h0000, 1'b1, 1'b1, 6'b000000, 16'hA010, 1'b0}, // R3 clears, R4 stays
    {1'b0, 16'h0000, 1'b1, 1'b1, 6'b000100, 16'hA018, 1'b1}, // R10 new rising edge
    {1'b0, 16'h0000, 1'b1, 1'b1, 6'b000011, 16'hA030, 1'b0}, // R5 guard set, not enabled
    {1'b0, 16'h0000, 1'b1, 1'b1, 6'b100000, 16'hA031, 1'b0}, // R5 no acc write: holds
    {1'b0, 16'h0000, 1'b1, 1'b1, 6'b000010, 16'hA010, 1'b0}, // R5 fits 32: clears
    {1'b1, 16'hC000, 1'b1, 1'b1, 6'b100111, 16'hC000, 1'b0}, // R7 write beats arith, R4 cleared
    {1'b0, 16'h0000, 1'b1, 1'b1, 6'b000011, 16'hC020, 1'b1}, // R10 guard-flag interrupt
    {1'b0, 16'h0000, 1'b0, 1'b1, 6'b111111, 16'hC020, 1'b0}, // R6 no op_valid
    {1'b1, 16'h4020, 1'b0, 1'b0, 6'b000000, 16'h4020, 1'b0}, // R10 global enable off
    {1'b1, 16'hC020, 1'b0, 1'b0, 6'b000000, 16'hC020, 1'b1}  // R10 global enable on
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 0; op_arith = 0; res_carry = 0; res_zero = 0; res_neg = 0;
    res_ovf = 0; acc_wr = 0; acc_ext = 0; sw_we = 0; sw_wdata = '0;
  endtask

  task automatic sw_write(input logic [15:0] v);
    @(negedge clk);
    sw_we = 1; sw_wdata = v;
    @(negedge clk);
    sw_we = 0; sw_wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    ext_irq_in = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status after reset", status, 16'h0000);
    chk("R1 irq after reset", {12'd0, ext_irq_req, ovf_irq}, 16'h0000);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      sw_we    = v[41];
      sw_wdata = v[40:25];
      op_valid = v[24];
      op_arith = v[23];
      {res_carry, res_zero, res_neg, res_ovf, acc_wr, acc_ext} = v[22:17];
      @(negedge clk);
      chk($sformatf("R2/R3/R4/R5/R6/R7 vector %0d status", i), status, v[16:1]);
      chk($sformatf("R10 vector %0d ovf_irq", i), {15'd0, ovf_irq}, {15'd0, v[0]});
    end
    idle_inputs();

    // R8 mode outputs follow bits 6..9
    sw_write(16'h03C0);
    chk("R8 mode pins", {12'd0, int_mult_mode, round_mode, clip_mode, dma_irq_en}, 16'h000F);
    // R8 arithmetic op does not touch control bits
    @(negedge clk);
    op_valid = 1; op_arith = 1; res_carry = 1; res_zero = 1; res_neg = 1; res_ovf = 1;
    acc_wr = 1; acc_ext = 1;
    @(negedge clk);
    idle_inputs();
    chk("R8 control bits after arith", status, 16'h03FF);

    // R9 external request gating
    sw_write(16'h8400);
    ext_irq_in = 3'b111;
    #1;
    chk("R9 only line 0 with GIE", {13'd0, ext_irq_req}, 16'h0001);
    sw_write(16'h1C00);
    chk("R9 all enables, no GIE", {13'd0, ext_irq_req}, 16'h0000);
    sw_write(16'h9800);
    ext_irq_in = 3'b101;
    #1;
    chk("R9 line 2 with GIE", {13'd0, ext_irq_req}, 16'h0004);
    ext_irq_in = '0;

    // R1 reset in mid-run
    sw_write(16'hFFFF);
    chk("R7 full write", status, 16'hFFFF);
    rst_n = 0;
    @(negedge clk);
    chk("R1 status after mid-run reset", status, 16'h0000);
    rst_n = 1;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule